// File: doc/BRIEF.md
# Pulse-Timed Internal Clock Period Trimmer

This block sets the period of an on-chip clock divider. The divider runs untrimmed from a default period and can be off by roughly thirty percent. A host corrects it by sending a calibration command and then holding the chip-select line low for a known time. The block counts fast reference clocks for as long as chip-select stays low. It takes that span to be 128 periods of the wanted internal clock, rounds the count to the nearest multiple of 128, and loads the quotient into the divider.

Pulses that are too short or too long for the allowed window are thrown away. When that happens the divider keeps its last accepted value, which is the default if no pulse has been accepted since reset. A sticky flag shows that at least one calibration has been accepted. Decoding of the command word happens upstream, so the block only receives a one-cycle command strobe.

Top module: `osc_trim_cal`

## Requirements
- R1: While reset is active and after it is released, `div_period` equals DEF_PERIOD (8) and `calibrated` is 0.
- R2: After a `cal_cmd` strobe, a low phase of `cs_n` lasting N reference cycles with MIN_PULSE (704) <= N <= MAX_PULSE (1344) loads `div_period` with (N + 64) >> 7 and sets `calibrated`. Both bounds are accepted.
- R3: The measurement counter never exceeds MAX_PULSE. A low phase of MAX_PULSE + 1 or more cycles is rejected, and the block disarms.
- R4: A low phase shorter than MIN_PULSE is rejected and the block disarms. A following low phase that has no new `cal_cmd` has no effect.
- R5: A rejected pulse leaves `div_period` at its last accepted value, or at DEF_PERIOD if nothing has been accepted.
- R6: Once set, `calibrated` stays 1 until reset, including across rejected pulses.
- R7: A low phase of `cs_n` that has no preceding `cal_cmd` does not change `div_period` or `calibrated`.
- R8: Measurement starts only at a high-to-low transition of `cs_n`. If `cal_cmd` arrives while `cs_n` is already low, that low phase is not measured, and the next full low phase is.
- R9: A `cal_cmd` strobe during a measurement is ignored, and the low phase is timed from its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_cmd | input | 1 | One-cycle strobe: calibration command decoded |
| cs_n | input | 1 | Chip-select line (active low), asynchronous to clk |
| div_period | output | DIV_W | Internal clock period in reference cycles |
| calibrated | output | 1 | Set once a pulse has been accepted |

## Verification
Three situations are hard to reach from the ports. The first is a command that arrives while chip-select is already low. The second is a command that lands in the middle of a measurement. The third is a pulse exactly one cycle either side of the window bounds. Directed sequences hold `cs_n` low across the command strobe and cover all four bound lengths. A seeded random phase then mixes armed and unarmed pulses whose lengths straddle both ends of the window. A reference model in the bench tracks the armed state alongside the design.

// File: rtl/osc_cal_pkg.sv
// Package: shared types for the pulse-timed period trimmer.
// Assumes: nothing beyond IEEE 1800-2017.
package osc_cal_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_MEASURE = 2'd2
    } cal_state_t;
endpackage

// File: rtl/cs_sync_edge.sv
// Module: brings the asynchronous chip-select into the clk domain and
// flags its high-to-low transitions.
// Assumes: cs_n idles high; reset value of every stage is 1.
module cs_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    output logic cs_low,
    output logic cs_fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift chip-select through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[STAGES-2:0], cs_n};
    end

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_q[STAGES-1];
    end

    // Decode the level and the falling edge.
    always_comb begin
        cs_low  = ~sync_q[STAGES-1];
        cs_fall = prev_q & ~sync_q[STAGES-1];
    end
endmodule

// File: rtl/pulse_meter.sv
// Module: arm/measure state machine. It counts reference cycles of a
// chip-select low phase and reports an in-window result.
// Assumes: cs_low/cs_fall are synchronous to clk. The counter saturates
// at MAX_PULSE, and reaching it while still low rejects the pulse.
module pulse_meter
    import osc_cal_pkg::*;
#(
    parameter int MIN_PULSE = 704,
    parameter int MAX_PULSE = 1344,
    parameter int CNT_W     = $clog2(MAX_PULSE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd,
    input  logic             cs_low,
    input  logic             cs_fall,
    output logic             done_ok,
    output logic [CNT_W-1:0] cnt,
    output cal_state_t       state
);
    localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_PULSE);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_PULSE);

    cal_state_t       state_d;
    logic [CNT_W-1:0] cnt_d;
    logic             ok_d;

    // Next-state, counter and acceptance decision.
    always_comb begin
        state_d = state;
        cnt_d   = cnt;
        ok_d    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cmd) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (cs_fall) begin
                    state_d = ST_MEASURE;
                    cnt_d   = CNT_W'(1);
                end
            end
            ST_MEASURE: begin
                if (cs_low) begin
                    if (cnt == MAX_C) state_d = ST_IDLE;
                    else              cnt_d   = cnt + CNT_W'(1);
                end else begin
                    state_d = ST_IDLE;
                    ok_d    = (cnt >= MIN_C);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Register state, counter and the one-cycle accept strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            done_ok <= 1'b0;
        end else begin
            state   <= state_d;
            cnt     <= cnt_d;
            done_ok <= ok_d;
        end
    end
endmodule

// File: rtl/trim_reg.sv
// Module: holds the divider period and the calibrated flag. It loads the
// rounded quotient count/2^SHIFT on an accept strobe.
// Assumes: cnt is stable in the cycle done_ok is high.
module trim_reg #(
    parameter int CNT_W       = 11,
    parameter int DIV_W       = 8,
    parameter int SHIFT       = 7,
    parameter int DEF_PERIOD  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] cnt,
    output logic [DIV_W-1:0] period,
    output logic             calibrated
);
    localparam logic [CNT_W:0] HALF = (CNT_W+1)'(1 << (SHIFT - 1));

    logic [CNT_W:0]   sum;
    logic [DIV_W-1:0] rounded;

    // Round the pulse count to the nearest multiple of the ratio.
    always_comb begin
        sum     = {1'b0, cnt} + HALF;
        rounded = DIV_W'(sum >> SHIFT);
    end

    // Load on accept; otherwise hold the last value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period     <= DIV_W'(DEF_PERIOD);
            calibrated <= 1'b0;
        end else if (load) begin
            period     <= rounded;
            calibrated <= 1'b1;
        end
    end
endmodule

// File: rtl/osc_trim_cal.sv
// Module: top of the pulse-timed period trimmer. Chains synchronizer,
// meter and trim register.
// Assumes: cal_cmd is a one-cycle strobe in the clk domain.
module osc_trim_cal
    import osc_cal_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int SHIFT       = 7,
    parameter int DEF_PERIOD  = 8,
    parameter int MIN_PULSE   = 704,
    parameter int MAX_PULSE   = 1344,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cal_cmd,
    input  logic             cs_n,
    output logic [DIV_W-1:0] div_period,
    output logic             calibrated
);
    localparam int CNT_W = $clog2(MAX_PULSE + 1);

    logic             cs_low;
    logic             cs_fall;
    logic             done_ok;
    logic [CNT_W-1:0] meas_cnt;
    cal_state_t       meas_state;

    cs_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .cs_low  (cs_low),
        .cs_fall (cs_fall)
    );

    pulse_meter #(
        .MIN_PULSE (MIN_PULSE),
        .MAX_PULSE (MAX_PULSE),
        .CNT_W     (CNT_W)
    ) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cal_cmd),
        .cs_low  (cs_low),
        .cs_fall (cs_fall),
        .done_ok (done_ok),
        .cnt     (meas_cnt),
        .state   (meas_state)
    );

    trim_reg #(
        .CNT_W      (CNT_W),
        .DIV_W      (DIV_W),
        .SHIFT      (SHIFT),
        .DEF_PERIOD (DEF_PERIOD)
    ) u_trim (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (done_ok),
        .cnt        (meas_cnt),
        .period     (div_period),
        .calibrated (calibrated)
    );
endmodule

// File: rtl/osc_trim_cal_chk.sv
// Checker: temporal properties of the trimmer, bound into its top.
// Assumes: the parameters match the bound instance.
module osc_trim_cal_chk
    import osc_cal_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int SHIFT      = 7,
    parameter int DEF_PERIOD = 8,
    parameter int MIN_PULSE  = 704,
    parameter int MAX_PULSE  = 1344,
    parameter int CNT_W      = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] div_period,
    input logic             calibrated,
    input logic             done_ok,
    input logic [CNT_W-1:0] meas_cnt,
    input cal_state_t       meas_state
);
    localparam int LO_P = (MIN_PULSE + (1 << (SHIFT - 1))) >> SHIFT;
    localparam int HI_P = (MAX_PULSE + (1 << (SHIFT - 1))) >> SHIFT;

    p_reset_default_r1: assert property (@(posedge clk)
        !rst_n |=> (div_period == DIV_W'(DEF_PERIOD) && !calibrated));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        meas_cnt <= CNT_W'(MAX_PULSE));

    p_accept_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_ok |-> (meas_cnt >= CNT_W'(MIN_PULSE) && meas_cnt <= CNT_W'(MAX_PULSE)));

    p_period_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        calibrated |-> (div_period >= DIV_W'(LO_P) && div_period <= DIV_W'(HI_P)));

    p_hold_unless_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !done_ok |=> $stable(div_period));

    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        calibrated |=> calibrated);

    p_measure_from_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_state == ST_IDLE) |=> (meas_state != ST_MEASURE));
endmodule

bind osc_trim_cal osc_trim_cal_chk #(
    .DIV_W      (DIV_W),
    .SHIFT      (SHIFT),
    .DEF_PERIOD (DEF_PERIOD),
    .MIN_PULSE  (MIN_PULSE),
    .MAX_PULSE  (MAX_PULSE),
    .CNT_W      (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .div_period (div_period),
    .calibrated (calibrated),
    .done_ok    (done_ok),
    .meas_cnt   (meas_cnt),
    .meas_state (meas_state)
);

// File: tb/sim_osc_trim_cal.sv
module sim_osc_trim_cal;
    localparam int DIV_W = 8;
    localparam int DEF_P = 8;
    localparam int MINP  = 704;
    localparam int MAXP  = 1344;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cal_cmd = 1'b0;
    logic             cs_n = 1'b1;
    logic [DIV_W-1:0] div_period;
    logic             calibrated;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int exp_p = DEF_P;
    bit exp_c = 1'b0;
    bit armed = 1'b0;

    always #4 clk = ~clk;

    osc_trim_cal u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cal_cmd    (cal_cmd),
        .cs_n       (cs_n),
        .div_period (div_period),
        .calibrated (calibrated)
    );

    function automatic int round_p(int n);
        return (n + 64) >> 7;
    endfunction

    function automatic bit in_win(int n);
        return (n >= MINP) && (n <= MAXP);
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_cmd();
        cal_cmd = 1'b1;
        tick(1);
        cal_cmd = 1'b0;
        tick(2);
        armed = 1'b1;
    endtask

    task automatic cs_pulse(int n);
        cs_n = 1'b0;
        tick(n);
        cs_n = 1'b1;
        tick(8);
        if (armed) begin
            if (in_win(n)) begin
                exp_p = round_p(n);
                exp_c = 1'b1;
            end
            armed = 1'b0;
        end
    endtask

    task automatic check(string req);
        checks++;
        if (int'(div_period) != exp_p || calibrated != exp_c) begin
            errors++;
            $display("FAIL %s: period=%0d cal=%0d expected period=%0d cal=%0d",
                     req, div_period, calibrated, exp_p, exp_c);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, expected end before limit");
        finish_run();
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'h5eed_0c17);
        tick(3);
        check("R1 during reset");
        tick(2);
        rst_n = 1'b1;
        tick(2);
        check("R1 after reset");

        cs_pulse(1000);
        check("R7 unarmed pulse");

        send_cmd();
        cs_pulse(MINP - 1);
        check("R4 short pulse");
        cs_pulse(1000);
        check("R4 disarmed after short");

        send_cmd();
        cs_pulse(MAXP + 1);
        check("R3 long pulse");
        cs_pulse(1000);
        check("R3 disarmed after overflow");

        send_cmd();
        cs_pulse(MINP);
        check("R2 min bound");
        send_cmd();
        cs_pulse(MAXP);
        check("R2 max bound");
        send_cmd();
        cs_pulse(1000);
        check("R2 mid pulse");

        send_cmd();
        cs_pulse(200);
        check("R5 keep last value, R6 flag");

        // R8: command while cs already low
        cs_n = 1'b0;
        tick(20);
        cal_cmd = 1'b1;
        tick(1);
        cal_cmd = 1'b0;
        tick(900);
        cs_n = 1'b1;
        tick(8);
        check("R8 low phase in progress not measured");
        armed = 1'b1;
        cs_pulse(1200);
        check("R8 next full pulse measured");

        // R9: command in mid-measurement
        send_cmd();
        armed = 1'b0;
        cs_n = 1'b0;
        tick(300);
        cal_cmd = 1'b1;
        tick(1);
        cal_cmd = 1'b0;
        tick(699);
        cs_n = 1'b1;
        tick(8);
        exp_p = round_p(1000);
        check("R9 command during measure ignored");

        for (int i = 0; i < 40; i++) begin
            int n;
            if ($urandom_range(3, 0) != 0) send_cmd();
            n = int'($urandom_range(MAXP + 120, MINP - 120));
            cs_pulse(n);
            check("R2/R5 random pulse");
        end

        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(2);
        exp_p = DEF_P;
        exp_c = 1'b0;
        armed = 1'b0;
        check("R1 R6 flag cleared by reset");
        send_cmd();
        cs_pulse(50);
        check("R5 default kept when never calibrated");

        finish_run();
    end
endmodule